// File: doc/BRIEF.md
# Dual-Clock FIFO with Fixed Read Latency

This FIFO carries data words from a producer clock domain to a consumer clock domain whose clocks are unrelated. The producer presents a word with `wr_req`. The word is taken on a write-clock edge only when the FIFO can accept it. Accepted words pass through one staging register and are then written into a register-array memory. The write count and read count cross between the domains as Gray code through two-flop synchronizers.

The consumer does not see data at zero latency. It raises `rd_req` to say it will be able to take a word `LAT` read-clock cycles later. Exactly `LAT` cycles after each request, `rd_valid` is high with the word on `rd_data` if one was available, and low if none was. There is no back-pressure on returned data: a word shown with `rd_valid` must be taken in that cycle, or it is lost. On the write side, `wr_ready` gates writes as soon as the stored count reaches capacity. `wr_full` follows one cycle later, and while it is high, requests are ignored. Capacity is `2**AW - MARGIN`, so the last `MARGIN` slots cover the write staging.

Each domain has an active-high asynchronous clear (enabled by `USE_ACLR`, not synchronized inside the block) and an active-high synchronous clear. `wr_req` must stay low during any clear.

Top module: `xclk_lat_fifo`

## Requirements
- R1: A word is accepted on a write-clock edge only if `wr_req`, `wr_ready` and not `wr_full` all hold before that edge. Requests made while `wr_full` or not `wr_ready` are ignored, and no such word ever reaches `rd_data`.
- R2: With no reads, exactly `2**AW - MARGIN` words are accepted. `wr_ready` is low in the cycle after the last of them.
- R3: `wr_full` is low in the first cycle `wr_ready` is low, and it rises one write-clock cycle later.
- R4: `rd_valid` is high only exactly `LAT` read-clock cycles after a cycle with `rd_req` high. A single request for a stored word yields `rd_valid` in exactly that cycle.
- R5: A request made when no word is available yields no `rd_valid` and consumes nothing.
- R6: Words appear on `rd_data` in acceptance order, each exactly once, under any mix of write and read request rates.
- R7: `rd_empty` is a registered flag that is high once the read-side count reaches zero. During a continuous drain, `rd_valid` stays high for up to `LAT-1` cycles after `rd_empty` rises.
- R8: A synchronous clear held in both domains leaves `wr_ready` high, `wr_full` low, `rd_empty` high and `rd_valid` low in the cycle after it. Earlier contents are discarded.
- R9: An asynchronous clear immediately forces `wr_full` low, `wr_ready` high, `rd_empty` high and `rd_valid` low without a clock edge. The FIFO works normally after the clear is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_aclr | input | 1 | Write-domain asynchronous clear, active high |
| wr_sclr | input | 1 | Write-domain synchronous clear, active high |
| wr_req | input | 1 | Write request (producer valid) |
| wr_data | input | DW | Write data |
| wr_ready | output | 1 | Write allowed; low protects the FIFO before `wr_full` rises |
| wr_full | output | 1 | Delayed full flag; requests ignored while high |
| rd_clk | input | 1 | Read clock |
| rd_aclr | input | 1 | Read-domain asynchronous clear, active high |
| rd_sclr | input | 1 | Read-domain synchronous clear, active high |
| rd_req | input | 1 | Read request: consumer ready `LAT` cycles later |
| rd_data | output | DW | Read data, meaningful only when `rd_valid` is high |
| rd_valid | output | 1 | Returned word valid; must be taken this cycle |
| rd_empty | output | 1 | Registered empty flag |

## Verification
The bench builds the block with `DW=16`, `AW=4`, `LAT=3`, `MARGIN=2` and asynchronous clears enabled. It runs a 50 MHz write clock against a 26 ns read clock, so the edges drift through every phase relation. A 16-slot memory with 14 usable entries fills within a few cycles, which puts the `wr_ready`/`wr_full` handoff and the ignored-request window within reach of short bursts. A latency of three makes the valid tail after `rd_empty` two cycles long and visible. The table phases mix saturated, starved and unbalanced request rates.

// File: rtl/xlf_pkg.sv
package xlf_pkg;

  function automatic logic [31:0] to_gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/xlf_sync.sv
module xlf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         aclr,
  input  logic         sclr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s [STAGES];

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      for (int i = 0; i < STAGES; i++) s[i] <= '0;
    end else if (sclr) begin
      for (int i = 0; i < STAGES; i++) s[i] <= '0;
    end else begin
      s[0] <= d;
      for (int i = 1; i < STAGES; i++) s[i] <= s[i-1];
    end
  end

  assign q = s[STAGES-1];
endmodule

// File: rtl/xlf_mem.sv
module xlf_mem #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];
  logic [DW-1:0] rq;

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rq <= store[raddr];
  end

  assign rdata = rq;
endmodule

// File: rtl/xlf_wr_ctrl.sv
module xlf_wr_ctrl #(
  parameter int DW     = 16,
  parameter int AW     = 4,
  parameter int MARGIN = 2
) (
  input  logic          clk,
  input  logic          aclr,
  input  logic          sclr,
  input  logic          req,
  input  logic [DW-1:0] din,
  input  logic [AW:0]   rgray_sync,
  output logic          ready,
  output logic          full,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic [AW:0]   wgray,
  output logic [AW:0]   ptr,
  output logic [AW:0]   used
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CAP   = DEPTH - MARGIN;

  logic [AW:0]   acc_ptr;
  logic [AW:0]   pub_ptr;
  logic [AW:0]   rbin;
  logic          full_q;
  logic          push;
  logic          st_v;
  logic [AW-1:0] st_a;
  logic [DW-1:0] st_d;
  logic [AW:0]   wgray_q;

  assign rbin  = PW'(xlf_pkg::from_gray(32'(rgray_sync)));
  assign used  = acc_ptr - rbin;
  assign ready = (used < PW'(CAP));
  assign push  = req & ready & ~full_q;

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      acc_ptr <= '0;
      pub_ptr <= '0;
      full_q  <= 1'b0;
      st_v    <= 1'b0;
      st_a    <= '0;
      st_d    <= '0;
      wgray_q <= '0;
    end else if (sclr) begin
      acc_ptr <= '0;
      pub_ptr <= '0;
      full_q  <= 1'b0;
      st_v    <= 1'b0;
      st_a    <= '0;
      st_d    <= '0;
      wgray_q <= '0;
    end else begin
      full_q  <= ~ready;
      st_v    <= push;
      if (push) begin
        acc_ptr <= acc_ptr + PW'(1);
        st_a    <= acc_ptr[AW-1:0];
        st_d    <= din;
      end
      if (st_v) pub_ptr <= pub_ptr + PW'(1);
      wgray_q <= PW'(xlf_pkg::to_gray(32'(pub_ptr)));
    end
  end

  assign full     = full_q;
  assign mem_we   = st_v;
  assign mem_addr = st_a;
  assign mem_data = st_d;
  assign wgray    = wgray_q;
  assign ptr      = acc_ptr;
endmodule

// File: rtl/xlf_rd_ctrl.sv
module xlf_rd_ctrl #(
  parameter int DW  = 16,
  parameter int AW  = 4,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          aclr,
  input  logic          sclr,
  input  logic          req,
  input  logic [AW:0]   wgray_sync,
  input  logic [DW-1:0] mem_q,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] data,
  output logic          valid,
  output logic          empty
);
  localparam int PW = AW + 1;

  logic [AW:0]    rd_ptr;
  logic [AW:0]    wbin;
  logic [AW:0]    level;
  logic [AW:0]    level_after;
  logic           pop;
  logic           empty_q;
  logic [LAT-1:0] vsh;
  logic [AW:0]    rgray_q;

  assign wbin        = PW'(xlf_pkg::from_gray(32'(wgray_sync)));
  assign level       = wbin - rd_ptr;
  assign pop         = req & (level != '0);
  assign level_after = level - PW'(pop);

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      rd_ptr  <= '0;
      empty_q <= 1'b1;
      vsh     <= '0;
      rgray_q <= '0;
    end else if (sclr) begin
      rd_ptr  <= '0;
      empty_q <= 1'b1;
      vsh     <= '0;
      rgray_q <= '0;
    end else begin
      if (pop) rd_ptr <= rd_ptr + PW'(1);
      empty_q <= (level_after == '0);
      vsh[0]  <= pop;
      for (int i = 1; i < LAT; i++) vsh[i] <= vsh[i-1];
      rgray_q <= PW'(xlf_pkg::to_gray(32'(rd_ptr)));
    end
  end

  generate
    if (LAT > 1) begin : g_dpipe
      logic [DW-1:0] dq [LAT-1];
      always_ff @(posedge clk) begin
        dq[0] <= mem_q;
        for (int i = 1; i < LAT - 1; i++) dq[i] <= dq[i-1];
      end
      assign data = dq[LAT-2];
    end else begin : g_dnone
      assign data = mem_q;
    end
  endgenerate

  assign mem_re   = pop;
  assign mem_addr = rd_ptr[AW-1:0];
  assign rgray    = rgray_q;
  assign valid    = vsh[LAT-1];
  assign empty    = empty_q;
endmodule

// File: rtl/xclk_lat_fifo.sv
module xclk_lat_fifo #(
  parameter int DW       = 16,
  parameter int AW       = 4,
  parameter int LAT      = 3,
  parameter int MARGIN   = 2,
  parameter int SYNC     = 2,
  parameter int USE_ACLR = 1
) (
  input  logic          wr_clk,
  input  logic          wr_aclr,
  input  logic          wr_sclr,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          wr_full,
  input  logic          rd_clk,
  input  logic          rd_aclr,
  input  logic          rd_sclr,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_empty
);
  localparam logic ACLR_EN = (USE_ACLR != 0);

  logic          wr_clr_a;
  logic          rd_clr_a;
  logic [AW:0]   wgray;
  logic [AW:0]   wgray_rs;
  logic [AW:0]   rgray;
  logic [AW:0]   rgray_ws;
  logic [AW:0]   wr_ptr;
  logic [AW:0]   wr_used;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic          mem_re;
  logic [AW-1:0] mem_raddr;
  logic [DW-1:0] mem_q;

  assign wr_clr_a = wr_aclr & ACLR_EN;
  assign rd_clr_a = rd_aclr & ACLR_EN;

  xlf_wr_ctrl #(.DW(DW), .AW(AW), .MARGIN(MARGIN)) wr_i (
    .clk(wr_clk), .aclr(wr_clr_a), .sclr(wr_sclr),
    .req(wr_req), .din(wr_data), .rgray_sync(rgray_ws),
    .ready(wr_ready), .full(wr_full),
    .mem_we(mem_we), .mem_addr(mem_waddr), .mem_data(mem_wdata),
    .wgray(wgray), .ptr(wr_ptr), .used(wr_used)
  );

  xlf_sync #(.W(AW+1), .STAGES(SYNC)) r2w_i (
    .clk(wr_clk), .aclr(wr_clr_a), .sclr(wr_sclr), .d(rgray), .q(rgray_ws)
  );

  xlf_sync #(.W(AW+1), .STAGES(SYNC)) w2r_i (
    .clk(rd_clk), .aclr(rd_clr_a), .sclr(rd_sclr), .d(wgray), .q(wgray_rs)
  );

  xlf_mem #(.DW(DW), .AW(AW)) mem_i (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .rclk(rd_clk), .re(mem_re), .raddr(mem_raddr), .rdata(mem_q)
  );

  xlf_rd_ctrl #(.DW(DW), .AW(AW), .LAT(LAT)) rd_i (
    .clk(rd_clk), .aclr(rd_clr_a), .sclr(rd_sclr),
    .req(rd_req), .wgray_sync(wgray_rs), .mem_q(mem_q),
    .mem_re(mem_re), .mem_addr(mem_raddr), .rgray(rgray),
    .data(rd_data), .valid(rd_valid), .empty(rd_empty)
  );
endmodule

// File: rtl/xlf_chk.sv
module xlf_chk #(
  parameter int AW     = 4,
  parameter int MARGIN = 2,
  parameter int LAT    = 3
) (
  input logic        wr_clk,
  input logic        wr_aclr,
  input logic        wr_sclr,
  input logic        wr_full,
  input logic        wr_ready,
  input logic [AW:0] wr_ptr,
  input logic [AW:0] wr_used,
  input logic        rd_clk,
  input logic        rd_aclr,
  input logic        rd_sclr,
  input logic        rd_req,
  input logic        rd_valid,
  input logic        rd_empty
);
  localparam int CAP = (1 << AW) - MARGIN;

  logic [LAT-1:0] req_sh;

  always_ff @(posedge rd_clk or posedge rd_aclr) begin
    if (rd_aclr) begin
      req_sh <= '0;
    end else if (rd_sclr) begin
      req_sh <= '0;
    end else begin
      req_sh[0] <= rd_req;
      for (int i = 1; i < LAT; i++) req_sh[i] <= req_sh[i-1];
    end
  end

  // R1: no acceptance while full
  a_r1_hold_when_full: assert property (@(posedge wr_clk) disable iff (wr_aclr || wr_sclr)
    wr_full |=> (wr_ptr == $past(wr_ptr)));

  // R2: stored count never passes the usable capacity
  a_r2_no_overflow: assert property (@(posedge wr_clk) disable iff (wr_aclr || wr_sclr)
    wr_used <= (AW+1)'(CAP));

  // R4: every valid answers a request exactly LAT cycles back
  a_r4_valid_latency: assert property (@(posedge rd_clk) disable iff (rd_aclr || rd_sclr)
    rd_valid |-> req_sh[LAT-1]);

  // R8: synchronous clear leaves the write side open
  a_r8_wr_clear: assert property (@(posedge wr_clk) disable iff (wr_aclr)
    wr_sclr |=> (wr_ready && !wr_full));

  // R8: synchronous clear leaves the read side empty and quiet
  a_r8_rd_clear: assert property (@(posedge rd_clk) disable iff (rd_aclr)
    rd_sclr |=> (rd_empty && !rd_valid));
endmodule

bind xclk_lat_fifo xlf_chk #(.AW(AW), .MARGIN(MARGIN), .LAT(LAT)) chk_i (
  .wr_clk(wr_clk), .wr_aclr(wr_aclr), .wr_sclr(wr_sclr),
  .wr_full(wr_full), .wr_ready(wr_ready), .wr_ptr(wr_ptr), .wr_used(wr_used),
  .rd_clk(rd_clk), .rd_aclr(rd_aclr), .rd_sclr(rd_sclr),
  .rd_req(rd_req), .rd_valid(rd_valid), .rd_empty(rd_empty)
);

// File: tb/xclk_lat_fifo_tb_top.sv
module xclk_lat_fifo_tb_top;
  localparam int DW  = 16;
  localparam int AW  = 4;
  localparam int LAT = 3;
  localparam int MRG = 2;
  localparam int CAP = (1 << AW) - MRG;

  // phase table: {word count[15:8], write rate[7:4], read rate[3:0]}; rate r means P = (r+1)/16
  localparam int NPH = 6;
  localparam logic [15:0] PH [NPH] = '{
    {8'd20, 4'd15, 4'd15},
    {8'd30, 4'd15, 4'd3},
    {8'd30, 4'd3,  4'd15},
    {8'd25, 4'd9,  4'd9},
    {8'd40, 4'd15, 4'd0},
    {8'd15, 4'd1,  4'd1}
  };

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_aclr = 1'b1, rd_aclr = 1'b1;
  logic          wr_sclr = 1'b0, rd_sclr = 1'b0;
  logic          wr_req = 1'b0, rd_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, wr_full, rd_valid, rd_empty;
  logic [DW-1:0] rd_data;

  int total = 0, bad = 0;
  int n_acc = 0, n_valid = 0;
  bit mon_en = 1'b0, saw_tail = 1'b0, done = 1'b0;
  logic [DW-1:0] seq = 16'h1000;
  logic [DW-1:0] exp_q [$];
  logic [LAT-1:0] hist = '0;

  always #10 wr_clk = ~wr_clk;
  always #13 rd_clk = ~rd_clk;

  xclk_lat_fifo #(.DW(DW), .AW(AW), .LAT(LAT), .MARGIN(MRG)) dut_i (
    .wr_clk(wr_clk), .wr_aclr(wr_aclr), .wr_sclr(wr_sclr), .wr_req(wr_req),
    .wr_data(wr_data), .wr_ready(wr_ready), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_aclr(rd_aclr), .rd_sclr(rd_sclr), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_empty(rd_empty)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge wr_clk) begin
    if (mon_en && wr_req && wr_ready && !wr_full) begin
      exp_q.push_back(wr_data);
      n_acc++;
    end
  end

  always @(negedge rd_clk) begin
    if (mon_en && rd_valid) begin
      n_valid++;
      chk(hist[LAT-1], "R4", "valid without request LAT cycles back", 1, 0);
      if (exp_q.size() == 0) chk(1'b0, "R6", "valid with nothing written", int'(rd_data), -1);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R6", "data order", int'(rd_data), int'(e));
      end
      if (rd_empty) saw_tail = 1'b1;
    end
    hist = {hist[LAT-2:0], rd_req};
  end

  task automatic do_write(int n, int rate);
    int sent = 0;
    while (sent < n) begin
      @(posedge wr_clk); #1;
      if (($urandom % 16) <= rate) begin
        wr_req = 1'b1; wr_data = seq;
      end else wr_req = 1'b0;
      @(negedge wr_clk);
      if (wr_req && wr_ready && !wr_full) begin
        sent++; seq = seq + 16'd1;
      end
    end
    @(posedge wr_clk); #1 wr_req = 1'b0;
  endtask

  task automatic do_read(int target, int rate);
    while (n_valid < target) begin
      @(posedge rd_clk); #1 rd_req = (($urandom % 16) <= rate);
    end
    @(posedge rd_clk); #1 rd_req = 1'b0;
  endtask

  task automatic sync_release();
    fork
      begin @(posedge wr_clk); #2 wr_aclr = 1'b0; end
      begin @(posedge rd_clk); #2 rd_aclr = 1'b0; end
    join
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base, tgt, v0, first;
    repeat (3) @(posedge wr_clk);
    sync_release();
    repeat (2) @(negedge wr_clk);
    // R9: state after the initial asynchronous clear
    chk(wr_ready == 1'b1, "R9", "ready after reset", int'(wr_ready), 1);
    chk(wr_full == 1'b0, "R9", "full after reset", int'(wr_full), 0);
    @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R9", "empty after reset", int'(rd_empty), 1);
    chk(rd_valid == 1'b0, "R9", "valid after reset", int'(rd_valid), 0);
    mon_en = 1'b1;

    // table walk: R6 order/integrity, R7 empty settles
    for (int p = 0; p < NPH; p++) begin
      tgt = n_valid + int'(PH[p][15:8]);
      fork
        do_write(int'(PH[p][15:8]), int'(PH[p][7:4]));
        do_read(tgt, int'(PH[p][3:0]));
      join
      repeat (6) @(negedge rd_clk);
      chk(exp_q.size() == 0, "R6", "words left after phase", exp_q.size(), 0);
      chk(rd_empty == 1'b1, "R7", "empty after phase", int'(rd_empty), 1);
    end

    // fill with no reads: R2 capacity, R3 delayed full, R1 ignored writes
    repeat (10) @(posedge wr_clk);
    base = n_acc;
    for (int k = 0; k < 40; k++) begin
      @(posedge wr_clk); #1 wr_req = 1'b1; wr_data = seq; seq = seq + 16'd1;
      @(negedge wr_clk);
      if (!wr_ready) break;
    end
    chk(n_acc - base == CAP, "R2", "accepted before ready low", n_acc - base, CAP);
    chk(wr_full == 1'b0, "R3", "full still low when ready drops", int'(wr_full), 0);
    @(posedge wr_clk); #1 wr_data = seq; seq = seq + 16'd1;
    @(negedge wr_clk);
    chk(wr_full == 1'b1, "R3", "full one cycle after ready", int'(wr_full), 1);
    for (int k = 0; k < 4; k++) begin
      @(posedge wr_clk); #1 wr_data = seq; seq = seq + 16'd1;
    end
    @(posedge wr_clk); #1 wr_req = 1'b0;
    chk(n_acc - base == CAP, "R1", "requests while full ignored", n_acc - base, CAP);

    // continuous drain: R7 valid tail after empty, R5 surplus requests
    tgt = n_valid + CAP;
    saw_tail = 1'b0;
    @(posedge rd_clk); #1 rd_req = 1'b1;
    repeat (CAP + 20) @(posedge rd_clk);
    #1 rd_req = 1'b0;
    repeat (6) @(negedge rd_clk);
    chk(n_valid == tgt, "R5", "valids during drain", n_valid, tgt);
    chk(saw_tail, "R7", "valid seen while empty high", int'(saw_tail), 1);
    chk(exp_q.size() == 0, "R1", "ignored words absent", exp_q.size(), 0);

    // single request latency: R4
    do_write(1, 15);
    repeat (10) @(posedge rd_clk);
    #1 rd_req = 1'b1;
    first = -1;
    for (int k = 0; k < 8; k++) begin
      @(negedge rd_clk);
      if (rd_valid && first < 0) first = k;
      @(posedge rd_clk); #1 rd_req = 1'b0;
    end
    chk(first == LAT, "R4", "request to valid cycles", first, LAT);

    // requests on an empty FIFO: R5
    v0 = n_valid;
    rd_req = 1'b1;
    repeat (10) @(posedge rd_clk);
    #1 rd_req = 1'b0;
    repeat (5) @(negedge rd_clk);
    chk(n_valid == v0, "R5", "valid from empty requests", n_valid - v0, 0);

    // synchronous clear: R8
    do_write(5, 15);
    repeat (10) @(posedge rd_clk);
    mon_en = 1'b0;
    fork
      begin @(posedge wr_clk); #1 wr_sclr = 1'b1; repeat (4) @(posedge wr_clk); #1 wr_sclr = 1'b0; end
      begin @(posedge rd_clk); #1 rd_sclr = 1'b1; repeat (4) @(posedge rd_clk); #1 rd_sclr = 1'b0; end
    join
    exp_q.delete();
    repeat (4) @(negedge wr_clk);
    chk(wr_ready == 1'b1 && wr_full == 1'b0, "R8", "write side after clear",
        int'({wr_ready, wr_full}), 2);
    @(negedge rd_clk);
    chk(rd_empty == 1'b1 && rd_valid == 1'b0, "R8", "read side after clear",
        int'({rd_empty, rd_valid}), 2);
    mon_en = 1'b1;
    v0 = n_valid;
    @(posedge rd_clk); #1 rd_req = 1'b1;
    repeat (10) @(posedge rd_clk);
    #1 rd_req = 1'b0;
    repeat (5) @(negedge rd_clk);
    chk(n_valid == v0, "R8", "old words discarded", n_valid - v0, 0);

    // asynchronous clear: R9
    do_write(5, 15);
    repeat (10) @(posedge rd_clk);
    mon_en = 1'b0;
    #7 wr_aclr = 1'b1; rd_aclr = 1'b1;
    #3;
    chk(wr_full == 1'b0 && wr_ready == 1'b1, "R9", "write side on async clear",
        int'({wr_ready, wr_full}), 2);
    chk(rd_empty == 1'b1 && rd_valid == 1'b0, "R9", "read side on async clear",
        int'({rd_empty, rd_valid}), 2);
    repeat (4) @(posedge rd_clk);
    sync_release();
    exp_q.delete();
    mon_en = 1'b1;
    repeat (4) @(posedge wr_clk);
    tgt = n_valid + 3;
    fork
      do_write(3, 15);
      do_read(tgt, 15);
    join
    repeat (6) @(negedge rd_clk);
    chk(n_valid == tgt && exp_q.size() == 0, "R9", "traffic after async clear",
        n_valid, tgt);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule